// File: doc/BRIEF.md
# Frame-Strobe Supervisory Timer

This block supervises an external microcontroller and drives that processor's reset pin. It does not count cycles of the fast system clock. It counts falling edges of a slow frame-strobe input, which it samples into the system clock domain. Firmware keeps the output low by writing a fixed key value to one register address, at least once per timeout interval. At the nominal 8 kHz strobe rate, 4096 falling edges make an interval of 512 ms. The interval length is a parameter, so a test can use a much shorter one.

If an interval ends with no correct key write, the output goes high. It then inverts at the end of every later interval, so the processor sees a slow train of reset pulses until firmware writes the key again. A write that carries the wrong key does not change the output at once. It also does not restart the interval, so it has the same effect as a missing write. If the strobe stops, the count freezes and the timer can never expire.

Top module: `frame_watchdog`

## Requirements
- R1: While rst_n is low at a clock edge, alarm is high after that edge.
- R2: On the first clock edge with rst_n high, alarm goes low, and the interval count starts from zero.
- R3: The interval count advances by one for each high-to-low transition of frame_strobe. The strobe is sampled through a two-stage synchronizer, so the count moves three clock edges after the strobe falls. While frame_strobe holds still, alarm never changes by itself.
- R4: An interval expires on the LIMIT-th falling edge of the strobe after the last restart, provided no correct key write comes in that cycle.
- R5: A correct key write restarts the interval from zero and drives alarm low on the next clock. A correct key write has wr_en high, wr_addr equal to 8'h11, and wr_data[4:0] equal to 5'b01010. The value of wr_data[7:5] does not matter.
- R6: A write to any address other than 8'h11 has no effect, even if it carries the key.
- R7: A write to 8'h11 whose low five data bits differ from the key does not change alarm and does not restart the interval.
- R8: The first expiry after a restart drives alarm from low to high. Each later expiry inverts alarm.
- R9: A correct key write while alarm is toggling drives alarm low and starts a full new interval.
- R10: When a correct key write and an expiring strobe edge fall in the same cycle, the write takes priority. Alarm does not toggle, and the count returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| frame_strobe | input | 1 | Frame strobe, asynchronous to clk |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| alarm | output | 1 | Reset output towards the supervised processor |

## Verification
The assertions assume that each register write lasts exactly one clock cycle. They also assume that frame_strobe changes much more slowly than clk, so that every edge passes through the synchronizer and is seen as a separate falling edge. The stimulus meets both assumptions. Writes are driven for a single cycle, and the strobe holds each level for four clock periods. The one corner case that depends on exact timing, a key write landing on the expiring edge, is reached by waiting until the reference model predicts that edge.

// File: rtl/fw_pkg.sv
// Shared types and defaults for the frame-strobe supervisory timer.
// Assumes: nothing beyond IEEE 1800-2017 package semantics.
package fw_pkg;

    // Alarm sequencer states
    typedef enum logic [1:0] {
        WD_HOLD   = 2'd0,   // reset just released, output not yet cleared
        WD_ARMED  = 2'd1,   // supervising, output low
        WD_ALARM  = 2'd2    // at least one interval missed, output toggling
    } wd_state_e;

    localparam int unsigned FW_ADDR_W_DEF = 8;
    localparam int unsigned FW_DATA_W_DEF = 8;
    localparam int unsigned FW_KEY_W_DEF  = 5;

endpackage

// File: rtl/fw_strobe_edge.sv
// Brings the asynchronous frame strobe into the clk domain and flags
// each high-to-low transition for exactly one clk cycle.
// Assumes: the strobe holds each level for more than SYNC_STAGES+1 cycles.
module fw_strobe_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic fall_pulse
);
    localparam int unsigned HIST_W = SYNC_STAGES + 1;

    logic [HIST_W-1:0] hist_q;

    // Shift the strobe through the synchronizer plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '1;
        end else begin
            hist_q <= {hist_q[HIST_W-2:0], strobe_in};
        end
    end

    // A fall is an old sample high followed by a newer sample low
    always_comb begin
        fall_pulse = hist_q[HIST_W-1] & ~hist_q[HIST_W-2];
    end
endmodule

// File: rtl/fw_key_decode.sv
// Flags a write that hits the supervisory register with the correct key.
// Assumes: wr_en is a single-cycle strobe; upper data bits are don't-care.
module fw_key_decode #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned KEY_W  = 5,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h11,
    parameter logic [KEY_W-1:0]  KEY      = 5'b01010
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              key_ok
);
    localparam logic [DATA_W-1:0] KEY_MASK = DATA_W'((64'd1 << KEY_W) - 64'd1);
    localparam logic [DATA_W-1:0] KEY_EXT  = DATA_W'(KEY);

    // Address match and masked key compare
    always_comb begin
        key_ok = wr_en && (wr_addr == REG_ADDR) && ((wr_data & KEY_MASK) == KEY_EXT);
    end
endmodule

// File: rtl/fw_interval_timer.sv
// Counts strobe falls within one supervision interval and reports expiry.
// Assumes: LIMIT >= 2; restart has priority over a coincident tick.
module fw_interval_timer #(
    parameter int unsigned LIMIT = 4096,
    localparam int unsigned CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    output logic             expire,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    // Expiry is the last tick of an interval not overridden by a restart
    always_comb begin
        expire = tick && !restart && (cnt_q == LAST);
        count  = cnt_q;
    end

    // Interval counter: clear on restart or wrap, else step on each tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || expire) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/fw_alarm_seq.sv
// Drives the supervisory output: high in reset, low once released,
// inverted at each expiry, cleared by a correct key write.
// Assumes: expire and key_ok are single-cycle, mutually exclusive pulses.
module fw_alarm_seq
    import fw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_ok,
    input  logic expire,
    output logic alarm
);
    wd_state_e state_q;
    logic      alarm_q;

    // Output sequencing over hold, armed and toggling phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_HOLD;
            alarm_q <= 1'b1;
        end else if (key_ok || state_q == WD_HOLD) begin
            state_q <= WD_ARMED;
            alarm_q <= 1'b0;
        end else if (expire) begin
            state_q <= WD_ALARM;
            alarm_q <= ~alarm_q;
        end
    end

    // Registered output straight to the pin
    always_comb begin
        alarm = alarm_q;
    end
endmodule

// File: rtl/frame_watchdog.sv
// Top of the frame-strobe supervisory timer. Joins the strobe edge
// detector, key decoder, interval counter and alarm sequencer.
// Assumes: all inputs except frame_strobe are synchronous to clk.
module frame_watchdog #(
    parameter int unsigned       ADDR_W      = fw_pkg::FW_ADDR_W_DEF,
    parameter int unsigned       DATA_W      = fw_pkg::FW_DATA_W_DEF,
    parameter int unsigned       KEY_W       = fw_pkg::FW_KEY_W_DEF,
    parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h11,
    parameter logic [KEY_W-1:0]  KEY         = 5'b01010,
    parameter int unsigned       LIMIT       = 4096,
    parameter int unsigned       SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_strobe,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              alarm
);
    localparam int unsigned CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic             strobe_fall;
    logic             key_ok;
    logic             expire;
    logic [CNT_W-1:0] tick_cnt;

    fw_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_in  (frame_strobe),
        .fall_pulse (strobe_fall)
    );

    fw_key_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W),
        .REG_ADDR(REG_ADDR), .KEY(KEY)
    ) u_key (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .key_ok  (key_ok)
    );

    fw_interval_timer #(.LIMIT(LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (strobe_fall),
        .restart (key_ok),
        .expire  (expire),
        .count   (tick_cnt)
    );

    fw_alarm_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .key_ok (key_ok),
        .expire (expire),
        .alarm  (alarm)
    );
endmodule

// File: rtl/frame_watchdog_chk.sv
// Property checker for frame_watchdog, bound into every instance.
// Assumes: single-cycle writes and a strobe far slower than clk.
module frame_watchdog_chk #(
    parameter int unsigned       ADDR_W   = 8,
    parameter int unsigned       DATA_W   = 8,
    parameter int unsigned       KEY_W    = 5,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h11,
    parameter logic [KEY_W-1:0]  KEY      = 5'b01010,
    parameter int unsigned       LIMIT    = 4096,
    parameter int unsigned       CNT_W    = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              alarm,
    input logic              fall,
    input logic [CNT_W-1:0]  cnt
);
    logic hit_reg, key_good, key_bad;
    always_comb begin
        hit_reg  = wr_en && (wr_addr == REG_ADDR);
        key_good = hit_reg && (wr_data[KEY_W-1:0] == KEY);
        key_bad  = hit_reg && (wr_data[KEY_W-1:0] != KEY);
    end

    // R1
    reset_high_chk: assert property (@(posedge clk) !rst_n |=> alarm);

    // R2
    release_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |=> (!alarm && cnt == '0));

    // R3
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !fall && !key_good) |=> $stable(alarm));

    // R7
    bad_key_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && key_bad && !fall) |=> $stable(alarm));

    // R9
    key_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_good |=> (!alarm && cnt == '0));

    // R8
    expiry_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && fall && !key_good && cnt == CNT_W'(LIMIT - 1))
        |=> (alarm != $past(alarm)));
endmodule

bind frame_watchdog frame_watchdog_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W),
    .REG_ADDR(REG_ADDR), .KEY(KEY), .LIMIT(LIMIT), .CNT_W(CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .alarm   (alarm),
    .fall    (strobe_fall),
    .cnt     (tick_cnt)
);

// File: tb/frame_watchdog_bench.sv
// Self-checking bench: behavioural reference model compared every cycle,
// plus scenario checks tagged with the requirement they cover.
module frame_watchdog_bench;
    localparam int unsigned LIMIT = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_strobe = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       alarm;

    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R1";
    bit    strobe_run = 1'b0;
    bit    done = 1'b0;

    frame_watchdog #(.LIMIT(LIMIT)) u_frame_watchdog (
        .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .alarm(alarm)
    );

    always #5 clk = ~clk;

    // Reference model state
    bit hist[$];
    int m_cnt = 0;
    bit m_alarm = 1'b1;
    bit m_hold = 1'b1;

    function automatic bit fall_next();
        return hist.size() >= 3 && hist[1] == 1'b0 && hist[2] == 1'b1;
    endfunction

    always @(posedge clk) begin
        bit good;
        bit fall;
        if (!rst_n) begin
            hist = '{1'b1, 1'b1, 1'b1};
            m_cnt = 0; m_alarm = 1'b1; m_hold = 1'b1;
        end else begin
            fall = fall_next();
            good = wr_en && wr_addr == 8'h11 && wr_data[4:0] == 5'b01010;
            if (m_hold) begin m_hold = 1'b0; m_alarm = 1'b0; end
            if (good) begin
                m_cnt = 0; m_alarm = 1'b0;
            end else if (fall) begin
                if (m_cnt == LIMIT - 1) begin m_cnt = 0; m_alarm = ~m_alarm; end
                else m_cnt++;
            end
            hist.push_front(frame_strobe);
            void'(hist.pop_back());
        end
    end

    task automatic check(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: alarm=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) if (!done) check({cur_req, " model"}, alarm, m_alarm);

    // Strobe generator: four clocks per level while running
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (strobe_run) begin
                ph++;
                if (ph == 4) begin frame_strobe = ~frame_strobe; ph = 0; end
            end
        end
    end

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: output high while held in reset
        wait_clk(4);
        check("R1", alarm, 1'b1);
        // R2: low on the first edge after release
        cur_req = "R2";
        rst_n = 1'b1;
        wait_clk(1);
        check("R2", alarm, 1'b0);
        // R3: stopped strobe never expires
        cur_req = "R3";
        wait_clk(200);
        check("R3", alarm, 1'b0);
        // R5: key writes (upper bits varied) keep the output low
        cur_req = "R5";
        strobe_run = 1'b1;
        for (int i = 0; i < 5; i++) begin
            wait_clk(38);
            wr(8'h11, (i % 2 == 0) ? 8'hEA : 8'h0A);
            check("R5", alarm, 1'b0);
        end
        // R6: key to another address does not restart
        cur_req = "R6";
        wait_clk(38);
        wr(8'h12, 8'h0A);
        wait_clk(38);
        check("R6", alarm, 1'b1);
        // R9: key write while alarmed clears and restarts
        cur_req = "R9";
        wr(8'h11, 8'h2A);
        check("R9", alarm, 1'b0);
        wait_clk(48);
        check("R9", alarm, 1'b0);
        // R7: wrong key, no immediate change and no restart
        cur_req = "R7";
        wr(8'h11, 8'h0B);
        check("R7", alarm, 1'b0);
        wait_clk(28);
        check("R7", alarm, 1'b1);
        // R4/R8: keeps toggling at the interval rate
        cur_req = "R8";
        wr(8'h11, 8'h0A);
        wait_clk(78);
        check("R4", alarm, 1'b1);
        wait_clk(64);
        check("R8", alarm, 1'b0);
        wait_clk(64);
        check("R8", alarm, 1'b1);
        wait_clk(64);
        check("R8", alarm, 1'b0);
        // R10: key write on the expiring edge wins
        cur_req = "R10";
        forever begin
            @(negedge clk);
            if (m_cnt == LIMIT - 1 && fall_next()) break;
        end
        wr_en = 1'b1; wr_addr = 8'h11; wr_data = 8'h4A;
        @(negedge clk); wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        check("R10", alarm, 1'b0);
        wait_clk(48);
        check("R10", alarm, 1'b0);
        wait_clk(40);
        finish_run();
    end
endmodule